// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-facing half of an asynchronous serial port. A byte-wide bus port reaches six registers: a status register, two control registers, the two halves of a 12-bit baud divisor, and a data register. A one-byte holding buffer sits behind the data register on the receive side, and three level interrupt lines report receive complete, data register empty and transmit complete. Bit-level shifting and baud timing are left to a neighbour. On the receive side that neighbour presents whole bytes on a valid/ready port. On the transmit side it takes each byte from a one-cycle strobe.

Transmission completes in the cycle the data register is written. A transmit-complete interrupt that is enabled clears its own flag as it fires. Every write to control register B recomputes all three interrupt lines from their enables and flags. Received bytes are masked to the configured character size when they are read. A power-reduction input holds the whole block in its reset state.

The receive holding buffer is a two-state machine. RX_EMPTY moves to RX_HELD on ACCEPT, when an inbound byte is taken. RX_HELD moves back to RX_EMPTY on CONSUME, a data read with the receiver enabled, or on FLUSH, a control B write that leaves the receiver disabled. Either state returns to RX_EMPTY on POWER-CLEAR, which is reset or power reduction.

Top module: `uart_regblock`

Bus offsets: 0 status A, 1 control B, 2 control C, 4 baud low, 5 baud high, 6 data; offsets 3 and 7 are unmapped. Status A bits: 7 receive-complete flag (RXC), 6 transmit-complete flag (TXC), 5 data-empty flag (DRE), 0 multiprocessor bit (stored only). Control B bits: 7 RXC interrupt enable, 6 TXC interrupt enable, 5 DRE interrupt enable, 4 receiver enable, 3 transmitter enable, 2 size bit 2, 1 read-only. Control C bits: 2 size bit 1, 1 size bit 0.

## Requirements
- R1: After reset, status A reads 0x20, control B 0x00, control C 0x06, both baud bytes 0x00, all interrupt lines are low and the holding buffer is empty.
- R2: A status A write replaces only bits 6, 1 and 0 (mask 0x43) and keeps the rest. Bit 6 (TXC) reads 0 afterwards, and a 1 written to bit 6 also drops irq_tx.
- R3: A control B write stores bits under mask 0xFD and keeps bit 1. If bit 4 (receiver enable) ends up 0, any held byte is discarded, while the RXC flag is kept.
- R4: After each control B write, irq_rx = B[7] & A[7], irq_tx = B[6] & A[6] and irq_dre = B[5] & A[5], using the new enables.
- R5: Every register reads back its stored value. Baud high keeps only its low 4 bits. Offsets 3 and 7 read 0x00 and ignore writes.
- R6: A data read with B[4]=0 returns 0x00 and changes nothing, so the RXC flag stays set.
- R7: A data read with B[4]=1 returns the held byte ANDed with the size mask, or 0x00 if nothing is held. It then empties the buffer, clears A[7] and drops irq_rx.
- R8: A data write with B[3]=0 does nothing. With B[3]=1 the byte appears on tx_byte with tx_strobe high in that cycle, and A[6] and A[5] are set. If B[6]=1, irq_tx rises and A[6] is cleared at once. If B[5]=1, irq_dre rises.
- R9: rx_ready is high only when B[4]=1 and the buffer is empty. An accepted byte is held, sets A[7] and raises irq_rx when B[7]=1.
- R10: The size code {B[2],C[2],C[1]} selects the read mask: 0 gives 0x1F, 1 gives 0x3F, 2 gives 0x7F, 3 and 7 give 0xFF. Codes 4 to 6 keep the previous mask. The mask is updated on B and C writes.
- R11: While pwr_off is high, the block returns to its reset state, reads give 0x00, writes are ignored and rx_ready is low.
- R12: In a cycle with a data read, rx_ready is low. An inbound byte offered then is taken on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_off | input | 1 | Power reduction; holds the block in reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; side effects commit on the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| rx_valid | input | 1 | Inbound byte offered |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Inbound byte can be taken this cycle |
| tx_strobe | output | 1 | Outbound byte emitted this cycle |
| tx_byte | output | 8 | Outbound byte |
| irq_rx | output | 1 | Receive-complete interrupt level |
| irq_dre | output | 1 | Data-empty interrupt level |
| irq_tx | output | 1 | Transmit-complete interrupt level |

## Verification
Several corner cases are targeted directly.

- Character sizes: received bytes of all ones are read under each size code, including a reserved code. A design that recomputed the mask on reserved codes would return eight bits where seven are expected.
- Receive priority: a byte is offered in the same cycle as a data read. A design that accepted it then would lose the byte or keep rx_ready high.
- Flush and disabled read: a flush is followed by a read with the receiver disabled. This exposes a design that clears the RXC flag on a disabled read, or that keeps the byte after the receiver is turned off.
- Interrupt recompute: interrupt enables are turned on after their flags are already set. A design that only raised lines on events would leave them low.

// File: rtl/uart_regblock_pkg.sv
package uart_regblock_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTLB  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTLC  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_BAUDL = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_BAUDH = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd6;

    // status A bit positions
    localparam int ST_RXC = 7;
    localparam int ST_TXC = 6;
    localparam int ST_DRE = 5;
    // control B bit positions
    localparam int CB_RXIE = 7;
    localparam int CB_TXIE = 6;
    localparam int CB_DRIE = 5;
    localparam int CB_RXEN = 4;
    localparam int CB_TXEN = 3;
    localparam int CB_SZ2  = 2;
    // control C bit positions
    localparam int CC_SZ1 = 2;
    localparam int CC_SZ0 = 1;

    localparam logic [BYTE_W-1:0] STAT_WMASK = 8'h43;
    localparam logic [BYTE_W-1:0] CTLB_WMASK = 8'hFD;
    localparam logic [BYTE_W-1:0] STAT_RST   = 8'h20;
    localparam logic [BYTE_W-1:0] CTLB_RST   = 8'h00;
    localparam logic [BYTE_W-1:0] CTLC_RST   = 8'h06;
    localparam logic [BYTE_W-1:0] MASK_RST   = 8'hFF;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_HELD  = 1'b1
    } rx_state_t;

    // character-size code to read mask; reserved codes keep the old mask
    function automatic logic [BYTE_W-1:0] size_mask(
        input logic [2:0]        code,
        input logic [BYTE_W-1:0] prev
    );
        logic [BYTE_W-1:0] m;
        m = prev;
        unique case (code)
            3'd0: m = 8'h1F;
            3'd1: m = 8'h3F;
            3'd2: m = 8'h7F;
            3'd3: m = 8'hFF;
            3'd7: m = 8'hFF;
            default: m = prev;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ur_rx_hold.sv
module ur_rx_hold
    import uart_regblock_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         accept,
    input  logic         consume,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic         held,
    output logic [W-1:0] dout
);

    rx_state_t state_q;
    rx_state_t state_d;
    logic [W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else if (clr) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (accept)            state_d = RX_HELD;
            RX_HELD:  if (consume || flush)  state_d = RX_EMPTY;
            default:                         state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (clr) begin
            byte_q <= '0;
        end else if (accept) begin
            byte_q <= din;
        end
    end

    always_comb begin
        held = (state_q == RX_HELD);
        dout = byte_q;
    end

endmodule

// File: rtl/ur_char_mask.sv
module ur_char_mask
    import uart_regblock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [2:0]        code,
    output logic [BYTE_W-1:0] mask
);

    logic [BYTE_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (clr) begin
            mask_q <= MASK_RST;
        end else if (upd) begin
            mask_q <= size_mask(code, mask_q);
        end
    end

    assign mask = mask_q;

endmodule

// File: rtl/ur_ctrl_regs.sv
module ur_ctrl_regs
    import uart_regblock_pkg::*;
#(
    parameter int BAUD_HI_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_stat,
    input  logic              wr_ctlb,
    input  logic              wr_ctlc,
    input  logic              wr_baudl,
    input  logic              wr_baudh,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_fire,
    input  logic              rx_take,
    input  logic              rd_take,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] ctlb_q,
    output logic [BYTE_W-1:0] ctlc_q,
    output logic [BYTE_W-1:0] baudl_q,
    output logic [BYTE_W-1:0] baudh_q,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_dre
);

    localparam logic [BYTE_W-1:0] HI_KEEP = BYTE_W'((1 << BAUD_HI_W) - 1);

    logic [BYTE_W-1:0] stat_d, ctlb_d, ctlc_d, baudl_d, baudh_d;
    logic irq_rx_d, irq_tx_d, irq_dre_d;

    always_comb begin
        stat_d    = stat_q;
        ctlb_d    = ctlb_q;
        ctlc_d    = ctlc_q;
        baudl_d   = baudl_q;
        baudh_d   = baudh_q;
        irq_rx_d  = irq_rx;
        irq_tx_d  = irq_tx;
        irq_dre_d = irq_dre;

        if (wr_stat) begin
            stat_d = (wdata & STAT_WMASK) | (stat_q & ~STAT_WMASK);
            if (wdata[ST_TXC]) begin
                stat_d[ST_TXC] = 1'b0;
                irq_tx_d       = 1'b0;
            end
        end
        if (wr_ctlb) begin
            ctlb_d    = (wdata & CTLB_WMASK) | (ctlb_q & ~CTLB_WMASK);
            irq_rx_d  = ctlb_d[CB_RXIE] & stat_q[ST_RXC];
            irq_tx_d  = ctlb_d[CB_TXIE] & stat_q[ST_TXC];
            irq_dre_d = ctlb_d[CB_DRIE] & stat_q[ST_DRE];
        end
        if (wr_ctlc)  ctlc_d  = wdata;
        if (wr_baudl) baudl_d = wdata;
        if (wr_baudh) baudh_d = wdata & HI_KEEP;

        if (tx_fire) begin
            stat_d[ST_TXC] = 1'b1;
            stat_d[ST_DRE] = 1'b1;
            if (ctlb_q[CB_TXIE]) begin
                irq_tx_d       = 1'b1;
                stat_d[ST_TXC] = 1'b0;
            end
            if (ctlb_q[CB_DRIE]) irq_dre_d = 1'b1;
        end
        if (rd_take) begin
            stat_d[ST_RXC] = 1'b0;
            irq_rx_d       = 1'b0;
        end
        if (rx_take) begin
            stat_d[ST_RXC] = 1'b1;
            if (ctlb_d[CB_RXIE]) irq_rx_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= STAT_RST;
            ctlb_q  <= CTLB_RST;
            ctlc_q  <= CTLC_RST;
            baudl_q <= '0;
            baudh_q <= '0;
            irq_rx  <= 1'b0;
            irq_tx  <= 1'b0;
            irq_dre <= 1'b0;
        end else if (clr) begin
            stat_q  <= STAT_RST;
            ctlb_q  <= CTLB_RST;
            ctlc_q  <= CTLC_RST;
            baudl_q <= '0;
            baudh_q <= '0;
            irq_rx  <= 1'b0;
            irq_tx  <= 1'b0;
            irq_dre <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            ctlb_q  <= ctlb_d;
            ctlc_q  <= ctlc_d;
            baudl_q <= baudl_d;
            baudh_q <= baudh_d;
            irq_rx  <= irq_rx_d;
            irq_tx  <= irq_tx_d;
            irq_dre <= irq_dre_d;
        end
    end

endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
    import uart_regblock_pkg::*;
#(
    parameter int BAUD_HI_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_off,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq_rx,
    output logic              irq_dre,
    output logic              irq_tx
);

    logic [BYTE_W-1:0] stat_q, ctlb_q, ctlc_q, baudl_q, baudh_q;
    logic [BYTE_W-1:0] held_byte, char_mask;
    logic              held;
    logic              live_wr, live_rd;
    logic              wr_stat, wr_ctlb, wr_ctlc, wr_baudl, wr_baudh;
    logic              data_rd, rd_take, rx_take, tx_fire, flush, mask_upd;
    logic [2:0]        size_code;

    assign live_wr  = bus_wr & ~pwr_off;
    assign live_rd  = bus_rd & ~pwr_off;
    assign wr_stat  = live_wr & (bus_addr == OFS_STAT);
    assign wr_ctlb  = live_wr & (bus_addr == OFS_CTLB);
    assign wr_ctlc  = live_wr & (bus_addr == OFS_CTLC);
    assign wr_baudl = live_wr & (bus_addr == OFS_BAUDL);
    assign wr_baudh = live_wr & (bus_addr == OFS_BAUDH);
    assign tx_fire  = live_wr & (bus_addr == OFS_DATA) & ctlb_q[CB_TXEN];
    assign data_rd  = live_rd & (bus_addr == OFS_DATA);
    assign rd_take  = data_rd & ctlb_q[CB_RXEN];
    assign flush    = wr_ctlb & ~bus_wdata[CB_RXEN];

    // a data read in the same cycle wins over an inbound byte
    assign rx_ready = ~pwr_off & ctlb_q[CB_RXEN] & ~held & ~data_rd;
    assign rx_take  = rx_valid & rx_ready;

    assign tx_strobe = tx_fire;
    assign tx_byte   = bus_wdata;

    assign mask_upd  = wr_ctlb | wr_ctlc;
    assign size_code = wr_ctlb ? {bus_wdata[CB_SZ2], ctlc_q[CC_SZ1], ctlc_q[CC_SZ0]}
                               : {ctlb_q[CB_SZ2], bus_wdata[CC_SZ1], bus_wdata[CC_SZ0]};

    ur_ctrl_regs #(.BAUD_HI_W(BAUD_HI_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_off),
        .wr_stat  (wr_stat),
        .wr_ctlb  (wr_ctlb),
        .wr_ctlc  (wr_ctlc),
        .wr_baudl (wr_baudl),
        .wr_baudh (wr_baudh),
        .wdata    (bus_wdata),
        .tx_fire  (tx_fire),
        .rx_take  (rx_take),
        .rd_take  (rd_take),
        .stat_q   (stat_q),
        .ctlb_q   (ctlb_q),
        .ctlc_q   (ctlc_q),
        .baudl_q  (baudl_q),
        .baudh_q  (baudh_q),
        .irq_rx   (irq_rx),
        .irq_tx   (irq_tx),
        .irq_dre  (irq_dre)
    );

    ur_rx_hold #(.W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_off),
        .accept  (rx_take),
        .consume (rd_take),
        .flush   (flush),
        .din     (rx_data),
        .held    (held),
        .dout    (held_byte)
    );

    ur_char_mask u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_off),
        .upd   (mask_upd),
        .code  (size_code),
        .mask  (char_mask)
    );

    always_comb begin
        bus_rdata = '0;
        if (live_rd) begin
            unique case (bus_addr)
                OFS_STAT:  bus_rdata = stat_q;
                OFS_CTLB:  bus_rdata = ctlb_q;
                OFS_CTLC:  bus_rdata = ctlc_q;
                OFS_BAUDL: bus_rdata = baudl_q;
                OFS_BAUDH: bus_rdata = baudh_q;
                OFS_DATA:  bus_rdata = (ctlb_q[CB_RXEN] && held) ? (held_byte & char_mask) : '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_off,
    input logic [2:0] bus_addr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_strobe,
    input logic       irq_rx,
    input logic       irq_dre,
    input logic       irq_tx,
    input logic [7:0] stat_q,
    input logic [7:0] ctlb_q,
    input logic [7:0] baudh_q
);

    AST_PWR_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |-> (bus_rdata == 8'h00) && !tx_strobe && !rx_ready); // R11

    AST_PWR_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> !irq_rx && !irq_tx && !irq_dre); // R11

    AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> ctlb_q[3]); // R8

    AST_TX_SETS_DRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && !pwr_off) |=> stat_q[5]); // R8

    AST_IRQ_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> stat_q[7]); // R9

    AST_IRQ_DRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dre |-> stat_q[5]); // R4

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready); // R9

    AST_READ_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd6 && ctlb_q[4] && !pwr_off) |=> !irq_rx && !stat_q[7]); // R7

    AST_READ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd6) |-> !rx_ready); // R12

    AST_BAUDH_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        baudh_q[7:4] == 4'h0); // R5

endmodule

bind uart_regblock uart_regblock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_off   (pwr_off),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .irq_rx    (irq_rx),
    .irq_dre   (irq_dre),
    .irq_tx    (irq_tx),
    .stat_q    (stat_q),
    .ctlb_q    (ctlb_q),
    .baudh_q   (baudh_q)
);

// File: tb/tb_uart_regblock.sv
`timescale 1ns/1ps
module tb_uart_regblock;

    localparam logic [2:0] A_ST = 3'd0, A_CB = 3'd1, A_CC = 3'd2, A_BL = 3'd4,
                           A_BH = 3'd5, A_DT = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_off = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_strobe, irq_rx, irq_dre, irq_tx;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_regblock dut (
        .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte),
        .irq_rx(irq_rx), .irq_dre(irq_dre), .irq_tx(irq_tx)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic push(input string req, input logic [7:0] d, input logic exp_ready);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        #1 chk(req, {7'd0, rx_ready}, {7'd0, exp_ready});
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic irqs_chk(input string req, input logic [2:0] exp);
        chk(req, {5'd0, irq_rx, irq_tx, irq_dre}, {5'd0, exp});
    endtask

    task automatic pwr_pulse;
        @(negedge clk);
        pwr_off = 1'b1;
        @(negedge clk);
        pwr_off = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 stat", A_ST, 8'h20);
        rd_chk("R1 ctlb", A_CB, 8'h00);
        rd_chk("R1 ctlc", A_CC, 8'h06);
        rd_chk("R1 baudl", A_BL, 8'h00);
        rd_chk("R1 baudh", A_BH, 8'h00);
        irqs_chk("R1 irqs", 3'b000);
        chk("R1 ready", {7'd0, rx_ready}, 8'h00);
    endtask

    task automatic t_regs;
        wr(A_BL, 8'hA5);
        rd_chk("R5 baudl", A_BL, 8'hA5);
        wr(A_BH, 8'hFF);
        rd_chk("R5 baudh nibble", A_BH, 8'h0F);
        wr(3'd3, 8'h55);
        rd_chk("R5 offset3", 3'd3, 8'h00);
        wr(3'd7, 8'h66);
        rd_chk("R5 offset7", 3'd7, 8'h00);
        rd_chk("R5 baudl kept", A_BL, 8'hA5);
        wr(A_CC, 8'h86);
        rd_chk("R5 ctlc", A_CC, 8'h86);
        pwr_pulse();
    endtask

    task automatic t_stat;
        wr(A_ST, 8'hFF);
        rd_chk("R2 masked write", A_ST, 8'h23);
        wr(A_ST, 8'h00);
        rd_chk("R2 clear low bits", A_ST, 8'h20);
        pwr_pulse();
    endtask

    task automatic t_ctlb;
        wr(A_CB, 8'hFF);
        rd_chk("R3 bit1 read-only", A_CB, 8'hFD);
        irqs_chk("R4 dre from flag", 3'b001);
        wr(A_CB, 8'h00);
        irqs_chk("R4 all dropped", 3'b000);
        pwr_pulse();
    endtask

    task automatic t_tx;
        @(negedge clk);
        bus_addr = A_DT; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #1 chk("R8 disabled no strobe", {7'd0, tx_strobe}, 8'h00);
        @(negedge clk); bus_wr = 1'b0;
        rd_chk("R8 disabled no flags", A_ST, 8'h20);
        wr(A_CB, 8'h08);
        @(negedge clk);
        bus_addr = A_DT; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #1 chk("R8 strobe", {7'd0, tx_strobe}, 8'h01);
        chk("R8 byte", tx_byte, 8'h3C);
        @(negedge clk); bus_wr = 1'b0;
        rd_chk("R8 flags set", A_ST, 8'h60);
        irqs_chk("R8 no irq", 3'b000);
        wr(A_CB, 8'h48);
        irqs_chk("R4 tx recompute", 3'b010);
        wr(A_ST, 8'h40);
        irqs_chk("R2 tx irq dropped", 3'b000);
        rd_chk("R2 txc cleared", A_ST, 8'h20);
        wr(A_CB, 8'h68);
        wr(A_DT, 8'h11);
        irqs_chk("R8 irqs raised", 3'b011);
        rd_chk("R8 txc auto-clear", A_ST, 8'h20);
        pwr_pulse();
    endtask

    task automatic t_rx;
        wr(A_CB, 8'h10);
        push("R9 ready when empty", 8'hC7, 1'b1);
        chk("R9 ready low when held", {7'd0, rx_ready}, 8'h00);
        rd_chk("R9 rxc set", A_ST, 8'hA0);
        irqs_chk("R9 no irq without enable", 3'b000);
        rd_chk("R7 data", A_DT, 8'hC7);
        rd_chk("R7 rxc cleared", A_ST, 8'h20);
        rd_chk("R7 empty read", A_DT, 8'h00);
        wr(A_CB, 8'h90);
        push("R9 ready", 8'h5A, 1'b1);
        irqs_chk("R9 rx irq", 3'b100);
        rd_chk("R7 data 2", A_DT, 8'h5A);
        irqs_chk("R7 rx irq dropped", 3'b000);
        pwr_pulse();
    endtask

    task automatic t_flush;
        wr(A_CB, 8'h10);
        push("R9 flush setup", 8'h55, 1'b1);
        wr(A_CB, 8'h00);
        rd_chk("R6 disabled read", A_DT, 8'h00);
        rd_chk("R6 rxc kept", A_ST, 8'hA0);
        wr(A_CB, 8'h10);
        chk("R3 buffer flushed", {7'd0, rx_ready}, 8'h01);
        rd_chk("R3 flushed data", A_DT, 8'h00);
        rd_chk("R7 rxc cleared", A_ST, 8'h20);
        pwr_pulse();
    endtask

    task automatic t_sizes;
        wr(A_CB, 8'h10);
        wr(A_CC, 8'h00);
        push("R10 s5", 8'hFF, 1'b1);
        rd_chk("R10 5 bits", A_DT, 8'h1F);
        wr(A_CC, 8'h02);
        push("R10 s6", 8'hFF, 1'b1);
        rd_chk("R10 6 bits", A_DT, 8'h3F);
        wr(A_CC, 8'h04);
        push("R10 s7", 8'hFF, 1'b1);
        rd_chk("R10 7 bits", A_DT, 8'h7F);
        wr(A_CB, 8'h14);
        push("R10 res", 8'hFF, 1'b1);
        rd_chk("R10 reserved keeps", A_DT, 8'h7F);
        wr(A_CC, 8'h06);
        push("R10 s9", 8'hFF, 1'b1);
        rd_chk("R10 nine as eight", A_DT, 8'hFF);
        pwr_pulse();
    endtask

    task automatic t_prio;
        wr(A_CB, 8'h10);
        @(negedge clk);
        bus_addr = A_DT; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h42;
        #1 chk("R12 ready low on read", {7'd0, rx_ready}, 8'h00);
        chk("R12 empty read", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0;
        #1 chk("R12 ready next cycle", {7'd0, rx_ready}, 8'h01);
        @(negedge clk);
        rx_valid = 1'b0;
        rd_chk("R12 byte taken later", A_DT, 8'h42);
        pwr_pulse();
    endtask

    task automatic t_power;
        wr(A_BL, 8'h77);
        wr(A_CB, 8'h38);
        irqs_chk("R11 setup dre", 3'b001);
        @(negedge clk);
        pwr_off = 1'b1;
        bus_addr = A_BL; bus_rd = 1'b1;
        #1 chk("R11 read zero", bus_rdata, 8'h00);
        chk("R11 ready low", {7'd0, rx_ready}, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h11;
        @(negedge clk);
        bus_wr = 1'b0;
        irqs_chk("R11 irqs low", 3'b000);
        pwr_off = 1'b0;
        rd_chk("R11 write ignored", A_BL, 8'h00);
        rd_chk("R11 ctlb reset", A_CB, 8'h00);
        rd_chk("R11 stat reset", A_ST, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_stat();
        t_ctlb();
        t_tx();
        t_rx();
        t_flush();
        t_sizes();
        t_prio();
        t_power();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule